// File: doc/BRIEF.md
# Graphics Write-Mask and Block-Fill Datapath

This block sits on the 32-bit data side of a synchronous graphics memory. It turns one command cycle into a registered write request for the array: a group base column, a set of column enables across an aligned group of eight columns, the write data, and a per-bit write enable. Plain writes pass bus data through under per-byte masks only. When the special-function flag is raised, a persistent bit-mask register limits which bits may change. A block fill writes a stored color value into any subset of eight adjacent columns in a single command.

On the read side the block produces a per-byte output enable. The byte-mask pins are sampled with a read command and take effect two cycles later, when the read data reaches the bus. On writes the same pins take effect in the cycle of the command. The mask and color registers load from the data bus only when the special-function flag qualifies the load. With the flag low, every graphics feature is out of the path.

Top module: `gwp_datapath`

## Requirements
- R1: After reset every output is zero, the bit-mask register holds all ones and the color register holds zero. A block fill issued before any load therefore writes data 0 with bit enables equal to the expanded byte enables.
- R2: A plain write (op=1 with sf=0) gives, one cycle later, wr_valid=1, wr_data = dq_in, wr_base = col_addr with its low 3 bits cleared, and wr_col_en one-hot at bit col_addr[2:0].
- R3: On any write, byte b of the bit enables (bits 8b+7..8b) is zero when dqm[b] is high at the command edge. This masking uses the same cycle as the command.
- R4: A masked write (op=1 with sf=1) gives bit enables equal to the bit-mask register ANDed with the expanded byte enables. Data, base and column enables follow R2.
- R5: A block fill (op=5 with sf=1) gives wr_col_en = dq_in[7:0], wr_data = the color register, an aligned wr_base, and bit enables equal to the bit-mask register ANDed with the expanded byte enables.
- R6: A load with sf=1 copies dq_in into the bit-mask register (op=3) or the color register (op=4). The value stays in effect across any number of later writes until the next such load.
- R7: With sf=0, op=3 and op=4 leave both registers unchanged, and op=5 behaves as a plain write per R2.
- R8: Two cycles after a read (op=2), rd_byte_oe[b] = NOT dqm[b] as sampled at the read edge. In every other case rd_byte_oe is zero.
- R9: One cycle after any command other than a write or a block fill (op 0, 2, 3, 4, 6, 7), wr_valid, wr_base, wr_col_en, wr_data and wr_bit_en are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Command: 0 none, 1 write, 2 read, 3 load mask, 4 load color, 5 block fill, 6/7 none |
| sf | input | 1 | Special-function qualifier |
| dq_in | input | 32 | Data bus input (write data, load value, or fill column enables in bits 7..0) |
| dqm | input | 4 | Per-byte masks; a high bit blocks that byte |
| col_addr | input | 8 | Column address of the command |
| wr_valid | output | 1 | Registered write request valid |
| wr_base | output | 8 | First column of the aligned 8-column group |
| wr_col_en | output | 8 | Per-column write enables within the group |
| wr_data | output | 32 | Data to write into every enabled column |
| wr_bit_en | output | 32 | Per-bit write enables |
| rd_byte_oe | output | 4 | Per-byte read output enable, two cycles after the read |

## Verification
The bench sweeps every dqm value under each command and flag combination, plus every low column-address value. A design that applied the read mask in the same cycle as the write mask, or that lost one stage of its delay, would show the wrong bytes enabled two cycles after a read. Loads issued with the flag low are followed by fills, so a register that loads without the qualifier shows up as a changed color or mask. Fills before any load expose a mask register that does not reset to all ones. Commands with unused op codes must leave the write outputs at zero.

// File: rtl/gwp_pkg.sv
package gwp_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WRITE  = 3'd1,
    OP_READ   = 3'd2,
    OP_LDMASK = 3'd3,
    OP_LDCOL  = 3'd4,
    OP_BLOCK  = 3'd5
  } gwp_op_e;
endpackage

// File: rtl/gwp_regs.sv
module gwp_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mask,
  input  logic              ld_color,
  input  logic              ld_ignored,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] color_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      color_q <= '0;
    end else begin
      if (ld_mask)  mask_q  <= dq_in;
      if (ld_color) color_q <= dq_in;
    end
  end

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_mask |=> mask_q == $past(dq_in));
  // R6
  color_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_color |=> color_q == $past(dq_in));
  // R7
  unqual_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ignored |=> ($stable(mask_q) && $stable(color_q)));
endmodule

// File: rtl/gwp_wr_merge.sv
module gwp_wr_merge #(
  parameter int DATA_W   = 32,
  parameter int COL_W    = 8,
  parameter int BLK_COLS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_go,
  input  logic                     mask_go,
  input  logic                     blk_go,
  input  logic [DATA_W-1:0]        dq_in,
  input  logic [DATA_W/8-1:0]      dqm,
  input  logic [COL_W-1:0]         col_addr,
  input  logic [DATA_W-1:0]        mask_q,
  input  logic [DATA_W-1:0]        color_q,
  output logic                     wr_valid,
  output logic [COL_W-1:0]         wr_base,
  output logic [BLK_COLS-1:0]      wr_col_en,
  output logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        wr_bit_en
);
  localparam int BYTES = DATA_W / 8;
  localparam int GRP_W = $clog2(BLK_COLS);

  logic [DATA_W-1:0]   byte_bits;
  logic [DATA_W-1:0]   nxt_bits;
  logic [DATA_W-1:0]   nxt_data;
  logic [BLK_COLS-1:0] nxt_cols;
  logic [COL_W-1:0]    grp_base;
  logic                any_go;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_bits[b*8 +: 8] = {8{~dqm[b]}};
  end

  assign any_go   = wr_go | blk_go;
  assign grp_base = {col_addr[COL_W-1:GRP_W], {GRP_W{1'b0}}};

  always_comb begin
    nxt_bits = (blk_go || mask_go) ? (mask_q & byte_bits) : byte_bits;
    nxt_data = blk_go ? color_q : dq_in;
    nxt_cols = blk_go ? dq_in[BLK_COLS-1:0]
                      : (BLK_COLS'(1) << col_addr[GRP_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || !any_go) begin
      wr_valid  <= 1'b0;
      wr_base   <= '0;
      wr_col_en <= '0;
      wr_data   <= '0;
      wr_bit_en <= '0;
    end else begin
      wr_valid  <= 1'b1;
      wr_base   <= grp_base;
      wr_col_en <= nxt_cols;
      wr_data   <= nxt_data;
      wr_bit_en <= nxt_bits;
    end
  end

  // R2
  plain_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> $countones(wr_col_en) == 1);
  // R2
  plain_data_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> wr_data == $past(dq_in));
  // R5
  fill_mask_chk: assert property (@(posedge clk) disable iff (rst)
    blk_go |=> (wr_bit_en & ~$past(mask_q)) == '0);
  // R3
  byte_block_chk: assert property (@(posedge clk) disable iff (rst)
    (any_go && dqm[0]) |=> wr_bit_en[7:0] == 8'h00);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !any_go |=> (!wr_valid && wr_col_en == '0 && wr_bit_en == '0));
endmodule

// File: rtl/gwp_rd_mask.sv
module gwp_rd_mask #(
  parameter int BYTES  = 4,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  logic [BYTES-1:0] dqm,
  output logic [BYTES-1:0] rd_byte_oe
);
  logic [BYTES-1:0] oe_pipe [RD_LAT];

  always_ff @(posedge clk) begin
    if (rst) oe_pipe[0] <= '0;
    else     oe_pipe[0] <= {BYTES{rd_go}} & ~dqm;
  end

  for (genvar s = 1; s < RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) oe_pipe[s] <= '0;
      else     oe_pipe[s] <= oe_pipe[s-1];
    end
  end

  assign rd_byte_oe = oe_pipe[RD_LAT-1];

  // R8
  rd_first_stage_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> oe_pipe[0] == ~$past(dqm));
  // R8
  rd_idle_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> oe_pipe[0] == '0);
endmodule

// File: rtl/gwp_datapath.sv
module gwp_datapath
  import gwp_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int COL_W    = 8,
  parameter int BLK_COLS = 8,
  parameter int RD_LAT   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            op,
  input  logic                  sf,
  input  logic [DATA_W-1:0]     dq_in,
  input  logic [DATA_W/8-1:0]   dqm,
  input  logic [COL_W-1:0]      col_addr,
  output logic                  wr_valid,
  output logic [COL_W-1:0]      wr_base,
  output logic [BLK_COLS-1:0]   wr_col_en,
  output logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     wr_bit_en,
  output logic [DATA_W/8-1:0]   rd_byte_oe
);
  localparam int BYTES = DATA_W / 8;

  logic wr_go, mask_go, blk_go, rd_go, ld_mask, ld_color, ld_ignored;
  logic [DATA_W-1:0] mask_q, color_q;

  always_comb begin
    wr_go      = (op == OP_WRITE) || (op == OP_BLOCK && !sf);
    mask_go    = (op == OP_WRITE) && sf;
    blk_go     = (op == OP_BLOCK) && sf;
    rd_go      = (op == OP_READ);
    ld_mask    = (op == OP_LDMASK) && sf;
    ld_color   = (op == OP_LDCOL) && sf;
    ld_ignored = (op == OP_LDMASK || op == OP_LDCOL) && !sf;
  end

  gwp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ld_mask(ld_mask), .ld_color(ld_color),
    .ld_ignored(ld_ignored), .dq_in(dq_in), .mask_q(mask_q), .color_q(color_q)
  );

  gwp_wr_merge #(.DATA_W(DATA_W), .COL_W(COL_W), .BLK_COLS(BLK_COLS)) u_merge (
    .clk(clk), .rst(rst), .wr_go(wr_go), .mask_go(mask_go), .blk_go(blk_go),
    .dq_in(dq_in), .dqm(dqm), .col_addr(col_addr), .mask_q(mask_q),
    .color_q(color_q), .wr_valid(wr_valid), .wr_base(wr_base),
    .wr_col_en(wr_col_en), .wr_data(wr_data), .wr_bit_en(wr_bit_en)
  );

  gwp_rd_mask #(.BYTES(BYTES), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst(rst), .rd_go(rd_go), .dqm(dqm), .rd_byte_oe(rd_byte_oe)
  );
endmodule

// File: tb/gwp_datapath_test.sv
module gwp_datapath_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = 3'd0;
  logic        sf = 1'b0;
  logic [31:0] dq_in = '0;
  logic [3:0]  dqm = '0;
  logic [7:0]  col_addr = '0;
  logic        wr_valid;
  logic [7:0]  wr_base;
  logic [7:0]  wr_col_en;
  logic [31:0] wr_data;
  logic [31:0] wr_bit_en;
  logic [3:0]  rd_byte_oe;

  int checks = 0;
  int errors = 0;

  gwp_datapath uut (
    .clk(clk), .rst(rst), .op(op), .sf(sf), .dq_in(dq_in), .dqm(dqm),
    .col_addr(col_addr), .wr_valid(wr_valid), .wr_base(wr_base),
    .wr_col_en(wr_col_en), .wr_data(wr_data), .wr_bit_en(wr_bit_en),
    .rd_byte_oe(rd_byte_oe)
  );

  always #5 clk = ~clk;

  // bench model state
  logic [31:0] m_mask = 32'hFFFF_FFFF;
  logic [31:0] m_color = '0;
  bit          m_loaded = 0;
  bit          m_ign = 0;
  logic        e_valid = 0;
  logic [7:0]  e_base = 0, e_cols = 0;
  logic [31:0] e_data = 0, e_bits = 0;
  logic [3:0]  e_rd0 = 0, e_rd1 = 0;
  string       t_cols = "R9", t_data = "R9", t_bits = "R9";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(logic [3:0] m);
    logic [31:0] e = '0;
    for (int b = 0; b < 4; b++) if (!m[b]) e[b*8 +: 8] = 8'hFF;
    return e;
  endfunction

  task automatic cyc(logic [2:0] o, logic s, logic [31:0] d, logic [3:0] m, logic [7:0] a);
    @(negedge clk);
    chk(t_cols, "wr_valid", 32'(wr_valid), 32'(e_valid));
    chk(t_cols, "wr_base", 32'(wr_base), 32'(e_base));
    chk(t_cols, "wr_col_en", 32'(wr_col_en), 32'(e_cols));
    chk(t_data, "wr_data", wr_data, e_data);
    chk(t_bits, "wr_bit_en", wr_bit_en, e_bits);
    chk("R8", "rd_byte_oe", 32'(rd_byte_oe), 32'(e_rd1));
    // R8: two-stage read expectation
    e_rd1 = e_rd0;
    e_rd0 = (o == 3'd2) ? ~m : 4'h0;
    if (o == 3'd1 || (o == 3'd5 && !s)) begin
      e_valid = 1; e_base = a & 8'hF8; e_cols = 8'(1) << a[2:0]; e_data = d;
      e_bits = s && o == 3'd1 ? (m_mask & expand(m)) : expand(m);
      t_cols = (o == 3'd5) ? "R7" : "R2";
      t_data = t_cols;
      t_bits = (o == 3'd1 && s) ? "R4" : "R3";
    end else if (o == 3'd5) begin
      e_valid = 1; e_base = a & 8'hF8; e_cols = d[7:0]; e_data = m_color;
      e_bits = m_mask & expand(m);
      t_cols = "R5";
      t_data = !m_loaded ? "R1" : (m_ign ? "R7" : "R6");
      t_bits = !m_loaded ? "R1" : "R5";
    end else begin
      e_valid = 0; e_base = 0; e_cols = 0; e_data = 0; e_bits = 0;
      t_cols = "R9"; t_data = "R9"; t_bits = "R9";
    end
    if (o == 3'd3 || o == 3'd4) begin
      if (s) begin
        if (o == 3'd3) m_mask = d; else m_color = d;
        m_loaded = 1; m_ign = 0;
      end else m_ign = 1;
    end
    op = o; sf = s; dq_in = d; dqm = m; col_addr = a;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk("R1", "wr_valid", 32'(wr_valid), 0);
    chk("R1", "wr_col_en", 32'(wr_col_en), 0);
    chk("R1", "wr_bit_en", wr_bit_en, 0);
    chk("R1", "rd_byte_oe", 32'(rd_byte_oe), 0);
    // R1: fill before any load uses reset mask and color
    cyc(3'd5, 1, 32'h0000_00A5, 4'h0, 8'h13);
    cyc(3'd5, 1, 32'h0000_005A, 4'h9, 8'h2C);
    // R2 R3: plain writes over all byte masks and low address bits
    for (int i = 0; i < 16; i++)
      cyc(3'd1, 0, 32'h1111_1111 * i + 32'hA050_0A05, 4'(i), 8'(i * 9));
    // R7: fill without qualifier is a plain write
    for (int i = 0; i < 8; i++)
      cyc(3'd5, 0, 32'hCAFE_0000 + i, 4'(i), 8'(i + 40));
    // R6: load mask and color
    cyc(3'd3, 1, 32'hF0F0_3C3C, 4'h0, 8'h00);
    cyc(3'd4, 1, 32'h1234_5678, 4'hF, 8'h00);
    // R4: masked writes, R5 R6: fills, interleaved to show persistence
    for (int i = 0; i < 16; i++) begin
      cyc(3'd1, 1, 32'hDEAD_BEEF ^ i, 4'(i), 8'(i * 5));
      cyc(3'd5, 1, 32'(8'(i * 37 + 1)), 4'(15 - i), 8'(i * 11));
      cyc(3'd1, 0, 32'h0F0F_0000 | i, 4'(i), 8'(i));
    end
    // R7: unqualified loads change nothing
    cyc(3'd3, 0, 32'h0000_0000, 4'h0, 8'h00);
    cyc(3'd4, 0, 32'hFFFF_FFFF, 4'h0, 8'h00);
    cyc(3'd5, 1, 32'h0000_00FF, 4'h0, 8'h77);
    cyc(3'd1, 1, 32'h5555_AAAA, 4'h0, 8'h78);
    // R8: reads over every byte mask, back to back and interleaved
    for (int i = 0; i < 16; i++) cyc(3'd2, 0, 32'h0, 4'(i), 8'(i));
    for (int i = 0; i < 16; i++) begin
      cyc(3'd2, 1, 32'h0, 4'(i), 8'(i));
      cyc(3'd1, 0, 32'(i), 4'(15 - i), 8'(i));
    end
    // R9 and full op/flag/mask sweep
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 16; m++)
          cyc(3'(o), s[0], 32'h9E37_79B9 * (o * 32 + s * 16 + m + 1), 4'(m),
              8'(o * 31 + m * 3 + s));
    cyc(3'd0, 0, 0, 0, 0);
    cyc(3'd0, 0, 0, 0, 0);
    cyc(3'd0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule